// File: doc/BRIEF.md
# ADC Continuous Scan Sequencer

This block sequences a successive-approximation converter through a contiguous set of analog channels, over and over, for as long as software leaves the run bit set. A single configuration write carries the run bit, the interrupt enable and the index of the highest channel in the set; the set always begins at channel 0. For each channel the sequencer runs a fixed-length sample phase, then holds a conversion request towards an external converter until that converter pulses its done line with a result. The result lands in that channel's own result register.

A conversion that follows a start from the wait state first waits for a 2-bit alignment counter to reach its top value. The conversions after it in the run skip that wait, so the first conversion takes longer than the rest. When the highest channel of the set completes, a sticky completion flag is raised and the interrupt output follows it when enabled. The scan then carries on from channel 0. Writing the run bit to 0 abandons whatever is in flight and parks the block. The next start begins at channel 0.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `samp_en`, `conv_req`, `done_flag` and `irq` are 0, `conv_ch` is 0 and every result register reads 0.
- R2: A free-running 2-bit alignment counter is 0 in the first cycle after reset and advances every clock. If it holds p in the cycle where a start write (`cfg_we`=1, `cfg_start`=1) is taken from the wait state, `samp_en` first rises (3 − p) cycles after the edge that takes the write.
- R3: `samp_en` stays high for exactly SAMP_CYC cycles. Then `conv_req` rises with `conv_ch` naming the channel, and both hold steady until `conv_done` is seen.
- R4: On the edge where `conv_done` is seen, `conv_data` is stored into the result register of `conv_ch`. The register for channel k sits at `res_flat[k*RES_W +: RES_W]`. No other result register changes, and no register changes without `conv_done`.
- R5: Channels are converted in ascending order from 0 up to the top of the set. After the top channel, conversion wraps to channel 0 and `samp_en` is high in the very next cycle, with no alignment wait; the run bit stays set.
- R6: `done_flag` rises on the edge that stores the top channel's result. It then stays 1 until `flag_clr` is pulsed. A completion on the same edge as `flag_clr` leaves it set.
- R7: `irq` is 1 exactly when `done_flag` is 1 and the stored interrupt enable is 1.
- R8: A write with `cfg_start`=0 takes the block to the wait state on that edge: `samp_en` and `conv_req` are 0 in the next cycle. The conversion in flight is dropped and its result register keeps its old value.
- R9: A start from the wait state always begins at channel 0, whichever channel was active when the block stopped.
- R10: A `cfg_top` value above NUM_CH−1 is treated as NUM_CH−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_start | input | 1 | Run bit written by `cfg_we` |
| cfg_ie | input | 1 | Interrupt enable written by `cfg_we` |
| cfg_top | input | CH_W | Highest channel of the set, written by `cfg_we` |
| flag_clr | input | 1 | Software clear of the completion flag |
| conv_done | input | 1 | Converter result-valid pulse |
| conv_data | input | RES_W | Converter result |
| samp_en | output | 1 | Sample phase active |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | CH_W | Channel being sampled or converted |
| res_flat | output | NUM_CH*RES_W | All result registers, channel k at bits k*RES_W upward |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong channel counter shows up on the very next write as a result in the wrong slot, or as a result out of order against the queue of expected results. A late or missing wrap shows up in the cycle the flag rises, through the last channel written and the state of `samp_en`. A sequencer that fails to park on stop shows a request or a sample phase one cycle after the stop write. An off-by-one in the alignment or sample counters moves the first `samp_en` or the first `conv_req` by whole cycles. The bench measures both against its own count of clock edges since reset.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_align_prescaler.sv
module adc_align_prescaler #(
  parameter int PW = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic align
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;

  always_comb cnt_d = cnt_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign align = &cnt_q;
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_W     = 4,
  parameter int SAMP_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_start,
  input  logic [CH_W-1:0] cfg_top,
  input  logic            align,
  input  logic            conv_done,
  output logic            samp_en,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_ch,
  output logic            res_we,
  output logic            pass_end
);
  localparam int SC_W = (SAMP_CYC > 1) ? $clog2(SAMP_CYC) : 1;
  localparam logic [CH_W-1:0] TOP_MAX  = CH_W'(NUM_CH - 1);
  localparam logic [SC_W-1:0] SAMP_END = SC_W'(SAMP_CYC - 1);

  seq_state_t      state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [CH_W-1:0] top_q, top_d;
  logic [SC_W-1:0] scnt_q, scnt_d;
  logic            go, stop;

  assign go   = cfg_we & cfg_start;
  assign stop = cfg_we & ~cfg_start;

  always_comb begin
    state_d  = state_q;
    ch_d     = ch_q;
    scnt_d   = scnt_q;
    res_we   = 1'b0;
    pass_end = 1'b0;
    top_d    = top_q;
    if (cfg_we) top_d = (cfg_top > TOP_MAX) ? TOP_MAX : cfg_top;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          ch_d    = '0;
          scnt_d  = '0;
          state_d = align ? ST_SAMPLE : ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (align) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (scnt_q == SAMP_END) state_d = ST_CONV;
        else                    scnt_d  = scnt_q + SC_W'(1);
      end
      ST_CONV: begin
        if (conv_done) begin
          res_we  = 1'b1;
          scnt_d  = '0;
          state_d = ST_SAMPLE;
          if (ch_q >= top_q) begin
            ch_d     = '0;
            pass_end = 1'b1;
          end else begin
            ch_d = ch_q + CH_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (stop) begin
      state_d  = ST_IDLE;
      res_we   = 1'b0;
      pass_end = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      top_q   <= '0;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      top_q   <= top_d;
      scnt_q  <= scnt_d;
    end
  end

  assign samp_en  = (state_q == ST_SAMPLE);
  assign conv_req = (state_q == ST_CONV);
  assign conv_ch  = ch_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [CH_W-1:0]         sel,
  input  logic [RES_W-1:0]        din,
  output logic [NUM_CH*RES_W-1:0] res_flat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    logic             slot_en;

    assign slot_en = we & (sel == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= din;
    end

    assign res_flat[g*RES_W +: RES_W] = slot_q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH   = 4,
  parameter int RES_W    = 10,
  parameter int CH_W     = 4,
  parameter int SAMP_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_start,
  input  logic                    cfg_ie,
  input  logic [CH_W-1:0]         cfg_top,
  input  logic                    flag_clr,
  input  logic                    conv_done,
  input  logic [RES_W-1:0]        conv_data,
  output logic                    samp_en,
  output logic                    conv_req,
  output logic [CH_W-1:0]         conv_ch,
  output logic [NUM_CH*RES_W-1:0] res_flat,
  output logic                    done_flag,
  output logic                    irq
);
  logic align, res_we, pass_end;
  logic flag_q, flag_d, ie_q, ie_d;

  adc_align_prescaler #(.PW(2)) i_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .align (align)
  );

  adc_scan_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SAMP_CYC(SAMP_CYC)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_start (cfg_start),
    .cfg_top   (cfg_top),
    .align     (align),
    .conv_done (conv_done),
    .samp_en   (samp_en),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .res_we    (res_we),
    .pass_end  (pass_end)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (res_we),
    .sel      (conv_ch),
    .din      (conv_data),
    .res_flat (res_flat)
  );

  always_comb begin
    flag_d = flag_q;
    if (pass_end)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    ie_d = cfg_we ? cfg_ie : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
    end
  end

  assign done_flag = flag_q;
  assign irq       = flag_q & ie_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic                    cfg_start,
  input logic                    flag_clr,
  input logic                    conv_done,
  input logic                    samp_en,
  input logic                    conv_req,
  input logic [CH_W-1:0]         conv_ch,
  input logic [NUM_CH*RES_W-1:0] res_flat,
  input logic                    done_flag,
  input logic                    irq
);
  logic stop_wr;
  assign stop_wr = cfg_we & ~cfg_start;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !stop_wr) |=> (conv_req && $stable(conv_ch))); // R3
  AST_RES_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(res_flat)); // R4
  AST_NEXT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && !stop_wr) |=> samp_en); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(conv_done)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag); // R7
  AST_STOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!conv_req && !samp_en)); // R8
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_start (cfg_start),
  .flag_clr  (flag_clr),
  .conv_done (conv_done),
  .samp_en   (samp_en),
  .conv_req  (conv_req),
  .conv_ch   (conv_ch),
  .res_flat  (res_flat),
  .done_flag (done_flag),
  .irq       (irq)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NUM_CH   = 4;
  localparam int RES_W    = 10;
  localparam int CH_W     = 4;
  localparam int SAMP_CYC = 3;
  localparam int LAT      = 2;

  logic                    clk, rst_n;
  logic                    cfg_we, cfg_start, cfg_ie, flag_clr;
  logic [CH_W-1:0]         cfg_top;
  logic                    conv_done;
  logic [RES_W-1:0]        conv_data;
  logic                    samp_en, conv_req, done_flag, irq;
  logic [CH_W-1:0]         conv_ch;
  logic [NUM_CH*RES_W-1:0] res_flat, prev_res, saved;

  int n_cmp = 0, n_bad = 0, ecnt = 0, wcnt = 0, wr_count = 0, last_ch = -1;
  logic [7:0]      seq = 8'd1;
  logic [CH_W-1:0] mute_ch = 4'hF;
  logic [31:0]     exp_q[$];

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W), .SAMP_CYC(SAMP_CYC)) i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start), .cfg_ie(cfg_ie),
    .cfg_top(cfg_top), .flag_clr(flag_clr), .conv_done(conv_done), .conv_data(conv_data),
    .samp_en(samp_en), .conv_req(conv_req), .conv_ch(conv_ch), .res_flat(res_flat),
    .done_flag(done_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor (scoreboard pop) and converter model (scoreboard push)
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_done = 1'b0; conv_data = '0; wcnt = 0; prev_res = '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (res_flat[k*RES_W +: RES_W] != prev_res[k*RES_W +: RES_W]) begin
          if (exp_q.size() == 0) check("R4 unexpected write", 32'(k), 32'hFFFF);
          else check("R4 result placement", {18'd0, 4'(k), res_flat[k*RES_W +: RES_W]}, exp_q.pop_front());
          last_ch = k;
          wr_count++;
        end
      end
      prev_res = res_flat;
      if (conv_done) begin
        conv_done = 1'b0;
        wcnt = 0;
      end else if (conv_req && conv_ch != mute_ch) begin
        if (wcnt == LAT - 1) begin
          conv_done = 1'b1;
          conv_data = {conv_ch[1:0], seq};
          exp_q.push_back({18'd0, conv_ch, conv_ch[1:0], seq});
          seq = seq + 8'd1;
          wcnt = 0;
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic write_cfg(input logic st, input logic ie, input logic [CH_W-1:0] top);
    cfg_we = 1'b1; cfg_start = st; cfg_ie = ie; cfg_top = top;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
  endtask

  task automatic wait_flag();
    while (!done_flag) step();
  endtask

  task automatic measure_start(input int k);
    int ew, p, n;
    repeat (k) step();
    ew = ecnt + 1;
    p  = (ew - 1) % 4;
    write_cfg(1'b1, 1'b1, 4'd0);
    while (!samp_en) step();
    check("R2 alignment delay", 32'(ecnt), 32'(ew + 3 - p));
    n = 0;
    while (samp_en) begin n++; step(); end
    check("R3 sample length", 32'(n), 32'(SAMP_CYC));
    check("R3 request after sample", 32'(conv_req), 32'd1);
    write_cfg(1'b0, 1'b1, 4'd0);
    check("R8 parked after stop", {30'd0, conv_req, samp_en}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_start = 1'b0; cfg_ie = 1'b0; cfg_top = '0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset outputs", {27'd0, samp_en, conv_req, done_flag, irq, 1'b0}, 32'd0);
    check("R1 reset channel", 32'(conv_ch), 32'd0);
    check("R1 reset results", 32'(res_flat != '0), 32'd0);

    // R2/R3 first-conversion timing at several alignment phases
    for (int k = 0; k < 4; k++) measure_start(k + 1);

    // R4/R5/R6/R7 full scan over channels 0..3 with interrupt enabled
    wr_count = 0;
    write_cfg(1'b1, 1'b1, 4'd3);
    wait_flag();
    check("R6 flag after top channel", 32'(last_ch), 32'd3);
    check("R5 ascending pass length", 32'(wr_count), 32'd4);
    check("R5 wrap to channel 0", 32'(conv_ch), 32'd0);
    check("R5 no alignment wait on wrap", 32'(samp_en), 32'd1);
    check("R7 irq with enable", 32'(irq), 32'd1);
    repeat (10) step();
    check("R6 flag sticky", 32'(done_flag), 32'd1);
    clear_flag();
    check("R6 flag cleared", 32'(done_flag), 32'd0);
    check("R7 irq follows flag", 32'(irq), 32'd0);

    // R7 interrupt disabled while scan keeps running
    write_cfg(1'b1, 1'b0, 4'd3);
    wait_flag();
    check("R7 irq masked", {30'd0, done_flag, irq}, 32'd2);
    clear_flag();

    // R3/R8 stall on channel 2 then stop
    mute_ch = 4'd2;
    while (!(conv_req && conv_ch == 4'd2)) step();
    repeat (3) step();
    check("R3 request held", {27'd0, conv_req, conv_ch}, {27'd0, 1'b1, 4'd2});
    saved = res_flat;
    write_cfg(1'b0, 1'b1, 4'd3);
    check("R8 stop drops request", {30'd0, conv_req, samp_en}, 32'd0);
    mute_ch = 4'hF;
    repeat (5) step();
    check("R8 result unchanged", 32'(res_flat == saved), 32'd1);

    // R9 restart at channel 0, R10 top clamp
    write_cfg(1'b1, 1'b1, 4'd15);
    while (!conv_req) step();
    check("R9 restart channel", 32'(conv_ch), 32'd0);
    wait_flag();
    check("R10 clamped top", 32'(last_ch), 32'd3);

    // R5 single-channel set
    write_cfg(1'b0, 1'b1, 4'd0);
    clear_flag();
    write_cfg(1'b1, 1'b1, 4'd0);
    wait_flag();
    check("R5 single channel pass", 32'(last_ch), 32'd0);
    check("R5 single channel wrap", 32'(conv_ch), 32'd0);
    write_cfg(1'b0, 1'b0, 4'd0);
    repeat (6) step();
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule